// File: doc/BRIEF.md
# Subcode Q Word Checker and Serial Reader

This block gathers the Q channel bit that arrives with each subcode frame. A block sync starts the gathering. The frames that carry sync are skipped, and the bits that follow make up one Q word: `DATA_BITS` data bits followed by a 16-bit check field. When the last bit of the word arrives, the block checks the word with a CRC. A word that fails the check is discarded without any sign at the outputs. A word that passes is copied into a holding register, and the ready flag rises.

An external controller watches the ready flag and then drives its own read clock. Before the first rising edge of that clock the first bit is already on the serial output. Each rising edge moves the output on to the next bit. The `msb_first` input chooses the bit order. The read clock is asynchronous to `clk`, so it is synchronised inside the block. The ready flag doubles as the read handshake. It drops when the read starts. It also drops when the hold window expires with no read.

The inbound Q stream has no back-pressure, because the disc cannot be paused: the block takes a bit on every frame strobe. The outbound stream is paced entirely by the controller's clock. A newly checked word never replaces a word that is being read.

Top module: `sq_q_reader`

## Requirements
- R1: After reset, `sq_ready` and `sq_data` are both 0.
- R2: After a `blk_sync` pulse, the block ignores the Q bits of the first `SYNC_FRAMES` frame strobes. The next `DATA_BITS` bits form the data word, and the first bit received becomes the word's most significant bit. The `CRC_W` bits after that form the check field, again with the first received bit as its MSB.
- R3: `sq_ready` rises only when the data word passes the CRC check. The CRC uses polynomial 0x1021 (x^16+x^12+x^5+1), starts from 0 and is fed MSB first. The word passes when the result equals the bitwise inverse of the received check field. A word that fails is dropped, and any word already held stays readable.
- R4: `sq_ready` is high within 2 `clk` cycles after the strobe that carries the last check bit.
- R5: When `msb_first` is 0, the word is shifted out LSB first; when it is 1, MSB first. The order is latched at the first read-clock rising edge, so changing `msb_first` during a read has no effect on that read.
- R6: The first bit is on `sq_data` before the first rising edge of `rd_clk`. Each rising edge advances the output by one bit. After `DATA_BITS` rising edges the read ends and `sq_data` returns to 0.
- R7: `sq_ready` falls on the first read-clock rising edge of a read.
- R8: A word that passes its check while a read is in progress is dropped. The read finishes with the old data, and `sq_ready` stays 0 afterwards.
- R9: If no read starts within `HOLD_CYCLES` cycles of the load, `sq_ready` falls. Read-clock edges after that move nothing, and `sq_data` stays 0.
- R10: A new passing word that arrives while the flag is up but before any read replaces the held word and restarts the hold window.
- R11: A `blk_sync` in the middle of a block throws away the partly gathered word.
- R12: Read-clock edges while the block is neither ready nor reading are ignored. A later read starts from bit 0.
- R13: Frame strobes after the word is complete, and before the next `blk_sync`, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_sync | input | 1 | One-cycle pulse at the start of a subcode block |
| frm_stb | input | 1 | One-cycle strobe; `q_bit` is valid with it |
| q_bit | input | 1 | Q channel bit of the current frame |
| rd_clk | input | 1 | Controller read clock, asynchronous |
| msb_first | input | 1 | 1: MSB first, 0: LSB first |
| sq_data | output | 1 | Serial Q data |
| sq_ready | output | 1 | A checked word is waiting to be read |

## Verification
The assertions assume that `blk_sync` and `frm_stb` are single-cycle pulses, and that each high and low phase of `rd_clk` lasts longer than the two-flop synchroniser plus its edge register. The bench holds each read-clock phase for four cycles and spaces frame strobes three cycles apart. It drives inputs on the falling edge of `clk` and samples outputs there. Under these conditions no edge is lost, and no two strobes arrive back to back.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  // one serial CRC step, MSB-first feed
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    logic [CRC_W-1:0] n;
    fb = c[CRC_W-1] ^ b;
    n = {c[CRC_W-2:0], 1'b0};
    if (fb) n = n ^ CRC_POLY;
    return n;
  endfunction
endpackage

// File: rtl/sq_rise_sync.sv
module sq_rise_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] && !prev_q;

  assert_single_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/sq_crc16.sv
module sq_crc16 (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic din,
  output logic [sq_pkg::CRC_W-1:0] crc
);
  import sq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc <= '0;
    else if (clr) crc <= '0;
    else if (en) crc <= crc_step(crc, din);
  end

  assert_crc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(crc));
endmodule

// File: rtl/sq_assembler.sv
module sq_assembler #(
  parameter int SYNC_FRAMES = 2,
  parameter int DATA_BITS = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic blk_sync,
  input  logic frm_stb,
  input  logic q_bit,
  output logic word_valid,
  output logic word_pass,
  output logic [DATA_BITS-1:0] word_data
);
  import sq_pkg::*;

  localparam int TOTAL = SYNC_FRAMES + DATA_BITS + CRC_W;
  localparam int FW = $clog2(TOTAL + 1);
  localparam logic [FW-1:0] DATA_LO = FW'(SYNC_FRAMES);
  localparam logic [FW-1:0] PAR_LO  = FW'(SYNC_FRAMES + DATA_BITS);
  localparam logic [FW-1:0] LAST    = FW'(TOTAL - 1);

  logic in_blk;
  logic [FW-1:0] fcnt;
  logic [CRC_W-1:0] par_sr;
  logic [CRC_W-1:0] crc;
  logic [CRC_W-1:0] final_par;
  logic take, in_data, in_par, pass_now;

  assign take     = frm_stb && in_blk && !blk_sync;
  assign in_data  = take && (fcnt >= DATA_LO) && (fcnt < PAR_LO);
  assign in_par   = take && (fcnt >= PAR_LO);
  assign final_par = {par_sr[CRC_W-2:0], q_bit};
  assign pass_now = (crc == ~final_par);

  sq_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(blk_sync), .en(in_data), .din(q_bit), .crc(crc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_blk     <= 1'b0;
      fcnt       <= '0;
      par_sr     <= '0;
      word_data  <= '0;
      word_valid <= 1'b0;
      word_pass  <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (blk_sync) begin
        in_blk <= 1'b1;
        fcnt   <= '0;
      end else if (take) begin
        fcnt <= fcnt + 1'b1;
        if (in_data) word_data <= {word_data[DATA_BITS-2:0], q_bit};
        if (in_par) par_sr <= final_par;
        if (fcnt == LAST) begin
          in_blk     <= 1'b0;
          word_valid <= 1'b1;
          word_pass  <= pass_now;
        end
      end
    end
  end

  assert_fcnt_bound_R13: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= FW'(TOTAL));
  assert_one_word_R13: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  assert_idle_after_word_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !blk_sync) |-> !in_blk);
endmodule

// File: rtl/sq_readout.sv
module sq_readout #(
  parameter int DATA_BITS = 80,
  parameter int HOLD_CYCLES = 189665
) (
  input  logic clk,
  input  logic rst_n,
  input  logic word_valid,
  input  logic word_pass,
  input  logic [DATA_BITS-1:0] word_data,
  input  logic rd_rise,
  input  logic msb_first,
  output logic sq_data,
  output logic sq_ready
);
  localparam int BW = $clog2(DATA_BITS);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [BW-1:0] LASTB = BW'(DATA_BITS - 1);
  localparam logic [HW-1:0] HLAST = HW'(HOLD_CYCLES - 1);

  logic [DATA_BITS-1:0] hold;
  logic reading, order_q, load, order_eff;
  logic [BW-1:0] bcnt, idx;
  logic [HW-1:0] tmr;

  assign load = word_valid && word_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold     <= '0;
      reading  <= 1'b0;
      sq_ready <= 1'b0;
      order_q  <= 1'b0;
      bcnt     <= '0;
      tmr      <= '0;
    end else if (reading) begin
      if (rd_rise) begin
        if (bcnt == LASTB) begin
          reading <= 1'b0;
          bcnt    <= '0;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end else if (sq_ready && rd_rise) begin
      reading  <= 1'b1;
      sq_ready <= 1'b0;
      order_q  <= msb_first;
      bcnt     <= BW'(1);
      tmr      <= '0;
    end else if (load) begin
      hold     <= word_data;
      sq_ready <= 1'b1;
      tmr      <= '0;
    end else if (sq_ready) begin
      if (tmr == HLAST) begin
        sq_ready <= 1'b0;
        tmr      <= '0;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  assign order_eff = reading ? order_q : msb_first;
  assign idx = order_eff ? (LASTB - bcnt) : bcnt;
  assign sq_data = (sq_ready || reading) ? hold[idx] : 1'b0;

  assert_ready_not_reading_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sq_ready && reading));
  assert_ready_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sq_ready) |-> $past(word_valid && word_pass));
  assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && load) |=> $stable(hold));
  assert_bitcnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= LASTB);
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!sq_ready && !reading) |-> (bcnt == '0));
  assert_order_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && $past(reading)) |-> $stable(order_q));
endmodule

// File: rtl/sq_q_reader.sv
module sq_q_reader #(
  parameter int SYNC_FRAMES = 2,
  parameter int DATA_BITS = 80,
  parameter int HOLD_CYCLES = 189665,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic blk_sync,
  input  logic frm_stb,
  input  logic q_bit,
  input  logic rd_clk,
  input  logic msb_first,
  output logic sq_data,
  output logic sq_ready
);
  logic word_valid, word_pass, rd_rise;
  logic [DATA_BITS-1:0] word_data;

  sq_rise_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(rd_clk), .rise(rd_rise)
  );

  sq_assembler #(.SYNC_FRAMES(SYNC_FRAMES), .DATA_BITS(DATA_BITS)) u_asm (
    .clk(clk), .rst_n(rst_n), .blk_sync(blk_sync), .frm_stb(frm_stb), .q_bit(q_bit),
    .word_valid(word_valid), .word_pass(word_pass), .word_data(word_data)
  );

  sq_readout #(.DATA_BITS(DATA_BITS), .HOLD_CYCLES(HOLD_CYCLES)) u_out (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_pass(word_pass),
    .word_data(word_data), .rd_rise(rd_rise), .msb_first(msb_first),
    .sq_data(sq_data), .sq_ready(sq_ready)
  );

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sq_ready) |-> $past(word_valid));
endmodule

// File: tb/tb_sq_q_reader.sv
module tb_sq_q_reader;
  localparam int NB = 16;
  localparam int SF = 2;
  localparam int HC = 400;

  logic clk = 0, rst_n = 0, blk_sync = 0, frm_stb = 0, q_bit = 0, rd_clk = 0, msb_first = 0;
  logic sq_data, sq_ready;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sq_q_reader #(.SYNC_FRAMES(SF), .DATA_BITS(NB), .HOLD_CYCLES(HC)) dut (
    .clk(clk), .rst_n(rst_n), .blk_sync(blk_sync), .frm_stb(frm_stb), .q_bit(q_bit),
    .rd_clk(rd_clk), .msb_first(msb_first), .sq_data(sq_data), .sq_ready(sq_ready)
  );

  function automatic logic [15:0] ref_crc(input logic [NB-1:0] d);
    logic [15:0] c = 16'h0;
    for (int i = NB - 1; i >= 0; i--) begin
      logic fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic b);
    q_bit = b; frm_stb = 1; cyc(1); frm_stb = 0; cyc(2);
  endtask

  task automatic send_block(input logic [NB-1:0] d, input logic [15:0] par);
    blk_sync = 1; cyc(1); blk_sync = 0; cyc(1);
    for (int i = 0; i < SF; i++) frame(1'b1);
    for (int i = NB - 1; i >= 0; i--) frame(d[i]);
    for (int i = 15; i >= 0; i--) frame(par[i]);
  endtask

  task automatic good_block(input logic [NB-1:0] d);
    send_block(d, ~ref_crc(d));
  endtask

  task automatic rd_edge;
    rd_clk = 1; cyc(4); rd_clk = 0; cyc(4);
  endtask

  function automatic logic exp_bit(input logic [NB-1:0] d, input logic msb, input int k);
    return msb ? d[NB-1-k] : d[k];
  endfunction

  // reads bits [from, to) of word d, checking each before its rising edge
  task automatic read_part(input string req, input logic [NB-1:0] d, input logic msb,
                           input int from, input int to);
    for (int k = from; k < to; k++) begin
      chk(req, sq_data, exp_bit(d, msb, k));
      rd_edge();
    end
  endtask

  initial begin
    cyc(200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] w, a, b;
    cyc(3);
    // R1 reset state
    chk("R1 ready", sq_ready, 1'b0);
    chk("R1 data", sq_data, 1'b0);
    rst_n = 1; cyc(2);
    chk("R1 ready after release", sq_ready, 1'b0);

    // R12 clocks while idle are ignored
    rd_edge(); rd_edge();
    chk("R12 idle data", sq_data, 1'b0);
    chk("R12 idle ready", sq_ready, 1'b0);

    // R2 R3 R4 R5 R6 R7 sweep of words and both orders
    for (int i = 0; i < 24; i++) begin
      w = NB'((i * 40503) ^ (i << 9) ^ 16'h5A3C);
      if (i == 0) w = '0;
      if (i == 1) w = '1;
      if (i == 2) w = NB'(1);
      msb_first = i[0];
      good_block(w);
      cyc(1);
      chk("R4 ready after last strobe", sq_ready, 1'b1);
      chk("R6 first bit before edge", sq_data, exp_bit(w, i[0], 0));
      rd_clk = 1; cyc(4);
      chk("R7 ready drops on read", sq_ready, 1'b0);
      rd_clk = 0; cyc(4);
      if (i == 5) msb_first = ~msb_first; // R5 order latched
      read_part("R2 R5 R6 data bit", w, i[0], 1, NB);
      chk("R6 data zero after read", sq_data, 1'b0);
      chk("R6 ready stays low", sq_ready, 1'b0);
    end

    // R3 failed CRC is dropped
    msb_first = 1;
    w = 16'hBEEF;
    send_block(w, ref_crc(w)); cyc(3);
    chk("R3 bad parity no ready", sq_ready, 1'b0);
    send_block(w, ~ref_crc(w) ^ 16'h0100); cyc(3);
    chk("R3 flipped parity bit no ready", sq_ready, 1'b0);
    // R3 failed word does not disturb a held word
    a = 16'h1357;
    good_block(a); cyc(2);
    send_block(16'h2468, 16'h0000); cyc(3);
    chk("R3 held word still ready", sq_ready, 1'b1);
    read_part("R3 held word kept", a, 1'b1, 0, NB);

    // R8 word arriving mid-read is dropped
    a = 16'hC0DE; b = 16'h7E81;
    good_block(a); cyc(2);
    read_part("R8 pre", a, 1'b1, 0, 3);
    good_block(b); cyc(3);
    chk("R8 no ready during read", sq_ready, 1'b0);
    read_part("R8 old data continues", a, 1'b1, 3, NB);
    chk("R8 new word dropped", sq_ready, 1'b0);

    // R9 hold window expiry
    a = 16'hA5A5;
    good_block(a); cyc(2);
    chk("R9 ready before expiry", sq_ready, 1'b1);
    cyc(HC + 20);
    chk("R9 ready expired", sq_ready, 1'b0);
    rd_edge();
    chk("R9 data zero after expiry", sq_data, 1'b0);
    chk("R9 no read started", sq_ready, 1'b0);

    // R10 newer passing word replaces held word and restarts window
    a = 16'h0F0F; b = 16'hF00D;
    good_block(a); cyc(2);
    good_block(b); cyc(300);
    chk("R10 window restarted", sq_ready, 1'b1);
    read_part("R10 replaced word", b, 1'b1, 0, NB);

    // R11 partial block discarded by a new sync
    a = 16'h9ABC;
    blk_sync = 1; cyc(1); blk_sync = 0; cyc(1);
    for (int i = 0; i < 9; i++) frame(1'b1);
    good_block(a); cyc(2);
    chk("R11 ready after clean block", sq_ready, 1'b1);
    read_part("R11 data", a, 1'b0 ^ 1'b1, 0, NB);

    // R13 extra strobes after the word are ignored
    a = 16'h4321;
    msb_first = 0;
    good_block(a);
    for (int i = 0; i < 20; i++) frame(i[0]);
    cyc(2);
    chk("R13 ready after extra strobes", sq_ready, 1'b1);
    read_part("R13 data", a, 1'b0, 0, NB);

    // R12 a read after idle edges starts at bit 0
    rd_edge();
    a = 16'h8001;
    good_block(a); cyc(2);
    read_part("R12 read from bit 0", a, 1'b0, 0, NB);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule